// File: doc/BRIEF.md
# Serial Register Bank Slave

This block lets an external controller reach a small bank of 8-bit control, status and trim registers over a four-wire serial link running in clock mode 0, most significant bit first. Each access is one frame of exactly sixteen serial clocks framed by an active-low select. The controller shifts in a command byte and then a data byte. While it does so, the slave shifts out two bytes. The first is always the system status value. The second is the contents of the addressed register.

The serial pins are taken into the system clock domain through two-flop synchronizers and handled by edge detection. The slave therefore needs a system clock several times faster than the serial clock. A write is committed only when the select rises at the end of a well-formed frame. Control registers drive a flat output bus, trim registers drive a separate bus, and the status register mirrors an input.

The register map is as follows:
- Control registers live at addresses 0x00–0x04, 0x07–0x0B and 0x0D. They appear on `ctrl_o` as bytes 0 to 10 in ascending address order.
- The status register is at 0x0C.
- A test location at 0x0E reads as zero.
- Trim registers are at 0x0F–0x11. They appear on `trim_o` as bytes 0 to 2.

Top module: `spi_reg_slave`

## Requirements
- R1: The command byte is laid out as follows: bit 7 is the direction (1 = read, 0 = write), bits 6:2 are the register address, bit 1 is unused and bit 0 is parity. The first byte returned in every frame equals `sys_status_i` as sampled when select falls, whatever the address or direction.
- R2: On a read, the second returned byte is the addressed register's contents. The master's data byte changes no register.
- R3: On a write, the second returned byte is the register's value before the write. The new data is stored once select rises.
- R4: A write is accepted only if the eight command bits hold an odd number of ones. A write with even parity changes no register. A read returns data whatever its parity bit.
- R5: A frame commits only if exactly 16 serial clock rising edges occurred between select falling and select rising. Shorter and longer frames change no register.
- R6: Addresses 0x05, 0x06, 0x0E and 0x12–0x1F read as 0x00, and writes to them are ignored.
- R7: Address 0x0C reads back `sys_status_i`. Writes to it change nothing.
- R8: The trim registers at 0x0F–0x11 read as 0x00 over the link. Their written values appear on `trim_o`, and reset clears them.
- R9: After reset, every control and trim register is 0x00 and `spi_miso` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| sys_status_i | input | 8 | System status value returned first in every frame |
| ctrl_o | output | 88 | Control registers, byte k = k-th control address |
| trim_o | output | 24 | Trim registers, byte k = address 0x0F + k |

## Verification
Each serial input passes through two synchronizer flops and one edge-detect stage. The output bit therefore moves three system cycles after a serial falling edge. The bench keeps a 40 ns half period, so it samples `spi_miso` a full half period after the edge that launched it. A committed write reaches `ctrl_o` or `trim_o` four system cycles after select rises. The bench holds select high for 20 cycles before it inspects the register buses or starts the next frame. The status byte is captured three cycles after select falls, and the bench leaves 80 ns before the first serial clock.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int DW      = 8;
    localparam int AW      = 5;
    localparam int NCTRL   = 11;
    localparam int NTRIM   = 3;
    localparam int FRAME_W = 2 * DW;
    localparam int CNT_W   = $clog2(FRAME_W) + 1;
    localparam int IDX_W   = 4;

    localparam logic [AW-1:0] ADDR_STAT  = 5'h0C;
    localparam logic [AW-1:0] ADDR_TEST  = 5'h0E;
    localparam logic [AW-1:0] ADDR_TRIM0 = 5'h0F;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_CTRL,
        KIND_TRIM,
        KIND_STAT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } reg_slot_t;

    typedef struct packed {
        logic [2:0]          sck_s;
        logic [2:0]          cs_s;
        logic [1:0]          mosi_s;
        logic [CNT_W-1:0]    cnt;
        logic [FRAME_W-1:0]  rx;
        logic [DW-1:0]       tx;
        logic                wr_req;
    } frame_t;

    typedef struct packed {
        logic [NCTRL-1:0][DW-1:0] ctrl;
        logic [NTRIM-1:0][DW-1:0] trim;
    } bank_t;

    // Map a register address onto its storage class and slot number.
    function automatic reg_slot_t decode_addr(input logic [AW-1:0] a);
        reg_slot_t s;
        s.kind = KIND_NONE;
        s.idx  = '0;
        if (a <= 5'h04) begin
            s.kind = KIND_CTRL;
            s.idx  = a[IDX_W-1:0];
        end else if (a >= 5'h07 && a <= 5'h0B) begin
            s.kind = KIND_CTRL;
            s.idx  = IDX_W'(a - 5'd2);
        end else if (a == 5'h0D) begin
            s.kind = KIND_CTRL;
            s.idx  = IDX_W'(NCTRL - 1);
        end else if (a == ADDR_STAT) begin
            s.kind = KIND_STAT;
        end else if (a >= ADDR_TRIM0 && a < ADDR_TRIM0 + AW'(NTRIM)) begin
            s.kind = KIND_TRIM;
            s.idx  = IDX_W'(a - ADDR_TRIM0);
        end
        return s;
    endfunction

endpackage

// File: rtl/spireg_frame.sv
module spireg_frame
    import spireg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          cs_n,
    input  logic          mosi,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          miso,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_par_ok
);

    frame_t f_d, f_q;

    logic sck_rise, sck_fall, cs_fall, cs_rise, active;

    always_comb begin
        sck_rise = f_q.sck_s[1] & ~f_q.sck_s[2];
        sck_fall = ~f_q.sck_s[1] & f_q.sck_s[2];
        cs_fall  = ~f_q.cs_s[1] & f_q.cs_s[2];
        cs_rise  = f_q.cs_s[1] & ~f_q.cs_s[2];
        active   = ~f_q.cs_s[1];

        f_d        = f_q;
        f_d.sck_s  = {f_q.sck_s[1:0], sck};
        f_d.cs_s   = {f_q.cs_s[1:0], cs_n};
        f_d.mosi_s = {f_q.mosi_s[0], mosi};
        f_d.wr_req = 1'b0;

        if (cs_fall) begin
            f_d.cnt = '0;
            f_d.tx  = status_i;
        end else if (active) begin
            if (sck_rise) begin
                f_d.rx = {f_q.rx[FRAME_W-2:0], f_q.mosi_s[1]};
                if (f_q.cnt != '1)
                    f_d.cnt = f_q.cnt + 1'b1;
            end
            if (sck_fall) begin
                if (f_q.cnt == CNT_W'(DW))
                    f_d.tx = rd_data;
                else
                    f_d.tx = {f_q.tx[DW-2:0], 1'b0};
            end
        end

        if (cs_rise)
            f_d.wr_req = (f_q.cnt == CNT_W'(FRAME_W)) && !f_q.rx[FRAME_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.sck_s <= '0;
            f_q.cs_s  <= '1;
        end else begin
            f_q <= f_d;
        end
    end

    assign rd_addr   = f_q.rx[DW-2 -: AW];
    assign miso      = f_q.tx[DW-1];
    assign wr_req    = f_q.wr_req;
    assign wr_addr   = f_q.rx[FRAME_W-2 -: AW];
    assign wr_data   = f_q.rx[DW-1:0];
    assign wr_par_ok = ^f_q.rx[FRAME_W-1:DW];

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.wr_req |-> f_q.cnt == CNT_W'(FRAME_W));

    // R1
    status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> f_q.tx == $past(status_i));

    // R3
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.wr_req |-> f_q.cs_s[2] && !f_q.cs_s[1] == 1'b0);

endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
    import spireg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_req,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic                wr_par_ok,
    input  logic [AW-1:0]       rd_addr,
    input  logic [DW-1:0]       status_i,
    output logic [DW-1:0]       rd_data,
    output logic [NCTRL*DW-1:0] ctrl_o,
    output logic [NTRIM*DW-1:0] trim_o
);

    bank_t     b_d, b_q;
    reg_slot_t wslot, rslot;
    logic      commit;

    always_comb begin
        wslot  = decode_addr(wr_addr);
        commit = wr_req && wr_par_ok;
        b_d    = b_q;
        for (int g = 0; g < NCTRL; g++) begin
            if (commit && wslot.kind == KIND_CTRL && wslot.idx == IDX_W'(g))
                b_d.ctrl[g] = wr_data;
        end
        for (int g = 0; g < NTRIM; g++) begin
            if (commit && wslot.kind == KIND_TRIM && wslot.idx == IDX_W'(g))
                b_d.trim[g] = wr_data;
        end
    end

    always_comb begin
        rslot   = decode_addr(rd_addr);
        rd_data = '0;
        if (rslot.kind == KIND_STAT)
            rd_data = status_i;
        for (int g = 0; g < NCTRL; g++) begin
            if (rslot.kind == KIND_CTRL && rslot.idx == IDX_W'(g))
                rd_data = b_q.ctrl[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            b_q <= '0;
        else
            b_q <= b_d;
    end

    assign ctrl_o = b_q.ctrl;
    assign trim_o = b_q.trim;

    // R4
    bad_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_par_ok) |=> $stable(b_q));

    // R6
    test_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && (wr_addr == ADDR_TEST || wr_addr == 5'h05 || wr_addr == 5'h06
                    || wr_addr > 5'h11)) |=> $stable(b_q));

    // R7
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr == ADDR_STAT) |=> $stable(b_q));

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spireg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sck,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic [DW-1:0]       sys_status_i,
    output logic [NCTRL*DW-1:0] ctrl_o,
    output logic [NTRIM*DW-1:0] trim_o
);

    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_req, wr_par_ok;

    spireg_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .status_i (sys_status_i),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .miso     (spi_miso),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_par_ok(wr_par_ok)
    );

    spireg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_par_ok(wr_par_ok),
        .rd_addr  (rd_addr),
        .status_i (sys_status_i),
        .rd_data  (rd_data),
        .ctrl_o   (ctrl_o),
        .trim_o   (trim_o)
    );

endmodule

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [7:0]  status = 8'hA5;
    logic [87:0] ctrl;
    logic [23:0] trim;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    spi_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .sys_status_i(status),
        .ctrl_o(ctrl), .trim_o(trim)
    );

    // {read, addr[4:0], data[7:0], expected second byte[7:0]}
    localparam int NV = 24;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 5'h00, 8'h3C, 8'h00},   // R3
        {1'b0, 5'h00, 8'hC3, 8'h3C},   // R3 old value returned
        {1'b1, 5'h00, 8'h00, 8'hC3},   // R2
        {1'b0, 5'h0B, 8'h5A, 8'h00},
        {1'b1, 5'h0B, 8'h00, 8'h5A},
        {1'b0, 5'h0F, 8'h77, 8'h00},   // R8
        {1'b1, 5'h0F, 8'h00, 8'h00},   // R8
        {1'b0, 5'h11, 8'h81, 8'h00},   // R8
        {1'b1, 5'h11, 8'h00, 8'h00},
        {1'b0, 5'h0E, 8'hFF, 8'h00},   // R6
        {1'b1, 5'h0E, 8'h00, 8'h00},
        {1'b0, 5'h05, 8'h11, 8'h00},   // R6
        {1'b1, 5'h05, 8'h00, 8'h00},
        {1'b0, 5'h06, 8'h12, 8'h00},
        {1'b1, 5'h06, 8'h00, 8'h00},
        {1'b0, 5'h1F, 8'h22, 8'h00},   // R6
        {1'b1, 5'h1F, 8'h00, 8'h00},
        {1'b1, 5'h0C, 8'h00, 8'hA5},   // R7
        {1'b0, 5'h0C, 8'h00, 8'hA5},   // R7
        {1'b1, 5'h0C, 8'h00, 8'hA5},
        {1'b0, 5'h0D, 8'h99, 8'h00},
        {1'b1, 5'h0D, 8'h00, 8'h99},
        {1'b0, 5'h04, 8'hE1, 8'h00},
        {1'b1, 5'h04, 8'hFF, 8'hE1}    // R2 data byte ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mkcmd(input logic rd, input logic [4:0] a, input logic bad);
        logic p;
        p = ~^{rd, a, 1'b0};
        return {rd, a, 1'b0, p ^ bad};
    endfunction

    task automatic frame(input logic [15:0] w, input int nclk, output logic [15:0] r);
        r = '0;
        cs_n = 1'b0;
        #80;
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            #40;
            sck = 1'b1;
            if (i < 16) r[15-i] = miso;
            #40;
            sck = 1'b0;
        end
        #40;
        cs_n = 1'b1;
        mosi = 1'b0;
        #100;
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] r;
        #50;
        // R9 reset state
        check("R9 miso", {31'd0, miso}, 32'd0);
        check("R9 ctrl", {31'd0, |ctrl}, 32'd0);
        check("R9 trim", {31'd0, |trim}, 32'd0);
        rst_n = 1'b1;
        #50;

        for (int k = 0; k < NV; k++) begin
            frame({mkcmd(VEC[k][21], VEC[k][20:16], 1'b0), VEC[k][15:8]}, 16, r);
            check("R1 status byte", {24'd0, r[15:8]}, 32'hA5);
            check("R2/R3 data byte", {24'd0, r[7:0]}, {24'd0, VEC[k][7:0]});
        end
        check("R3 ctrl 0x00", {24'd0, ctrl[7:0]}, 32'hC3);
        check("R3 ctrl 0x0B", {24'd0, ctrl[79:72]}, 32'h5A);
        check("R3 ctrl 0x0D", {24'd0, ctrl[87:80]}, 32'h99);
        check("R2 ctrl 0x04", {24'd0, ctrl[39:32]}, 32'hE1);
        check("R8 trim 0x0F", {24'd0, trim[7:0]}, 32'h77);
        check("R8 trim 0x11", {24'd0, trim[23:16]}, 32'h81);

        // R4 bad parity write ignored
        frame({mkcmd(1'b0, 5'h01, 1'b1), 8'h55}, 16, r);
        frame({mkcmd(1'b1, 5'h01, 1'b0), 8'h00}, 16, r);
        check("R4 bad parity write", {24'd0, r[7:0]}, 32'h00);
        // R4 read with wrong parity still answers
        frame({mkcmd(1'b1, 5'h00, 1'b1), 8'h00}, 16, r);
        check("R4 read parity ignored", {24'd0, r[7:0]}, 32'hC3);

        // R5 short and long frames discarded
        frame({mkcmd(1'b0, 5'h02, 1'b0), 8'hAA}, 12, r);
        check("R5 short frame", {24'd0, ctrl[23:16]}, 32'h00);
        frame({mkcmd(1'b0, 5'h02, 1'b0), 8'hAA}, 17, r);
        check("R5 long frame", {24'd0, ctrl[23:16]}, 32'h00);
        frame({mkcmd(1'b1, 5'h02, 1'b0), 8'h00}, 16, r);
        check("R5 readback", {24'd0, r[7:0]}, 32'h00);

        // R1 status follows input for any address
        status = 8'h3C;
        frame({mkcmd(1'b1, 5'h05, 1'b0), 8'h00}, 16, r);
        check("R1 status change", {24'd0, r[15:8]}, 32'h3C);

        // R8 R9 reset clears registers
        rst_n = 1'b0;
        #50;
        rst_n = 1'b1;
        #50;
        check("R8 trim cleared", {8'd0, trim}, 32'd0);
        check("R9 ctrl cleared", {31'd0, |ctrl}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule